// File: doc/BRIEF.md
# Timer interrupt flag controller

This block keeps the two interrupt flags of an 8-bit timer/counter that has one compare channel, and turns them into interrupt requests. The timer supplies a one-cycle compare-match strobe, its current count, its count direction and a PWM-mode select. From these the block finds overflow events on its own. In normal counting an overflow is the wrap from the all-ones value to zero. In PWM mode it is the turn of the count direction from down to up at the bottom value.

Software reaches a flag register and an enable register through a small bus port with select, read, write and data lines. A flag clears when software writes a one to its bit, or when the interrupt controller takes the matching vector and pulses the acknowledge strobe for that source. Each request output is high only while the global interrupt bit, the source's enable bit and the source's flag are all set.

Top module: `tmr_irq_flags`

## Requirements
- R1: A cycle with `cmp_match_i` high sets the compare flag (flag register bit 1) at that clock edge, so it reads as one from the next cycle on.
- R2: With `pwm_mode_i` low, a count of all ones followed on the next clock by a count of zero sets the overflow flag (flag register bit 0) at the edge where zero is sampled.
- R3: With `pwm_mode_i` high, the overflow flag sets at the edge where `dir_up_i` is sampled high, the previous sample had `dir_up_i` low and the previous count was zero. An all-ones-to-zero wrap sets nothing in this mode, and a direction turn sets nothing in normal mode.
- R4: A bus write with `bus_sel_i` = 0 clears every flag whose data bit is one and leaves flags whose data bit is zero unchanged.
- R5: A pulse on `ack_ovf_i` clears the overflow flag and a pulse on `ack_cmp_i` clears the compare flag, at the next clock edge.
- R6: When a set event and a clear (write of one or acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R7: `irq_ovf_o` equals `gie_i` AND enable bit 0 AND flag bit 0; `irq_cmp_o` equals `gie_i` AND enable bit 1 AND flag bit 1.
- R8: A read with `bus_sel_i` = 0 returns the overflow flag in bit 0 and the compare flag in bit 1; bits 7 to 2 read as zero and writes to them have no effect.
- R9: With `bus_sel_i` = 1 the enable register is written (bit 0 overflow enable, bit 1 compare enable) and read back in the same positions; its bits 7 to 2 read as zero.
- R10: Reset clears both flags and both enable bits; `bus_rdata_o` is zero whenever `bus_rd_i` is low.
- R11: A request output falls in the cycle after its flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 8 | Current timer count |
| dir_up_i | input | 1 | Count direction, 1 = counting up |
| pwm_mode_i | input | 1 | 1 = PWM (up/down) mode, 0 = normal mode |
| cmp_match_i | input | 1 | One-cycle compare-match strobe |
| gie_i | input | 1 | Global interrupt enable |
| ack_ovf_i | input | 1 | Overflow vector taken |
| ack_cmp_i | input | 1 | Compare vector taken |
| bus_sel_i | input | 1 | Register select: 0 flags, 1 enables |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational |
| flags_o | output | 2 | Registered flags, bit 0 overflow, bit 1 compare |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| irq_cmp_o | output | 1 | Compare interrupt request |

## Verification
Every flag change, whether from a compare strobe, a detected overflow, a write of one or an acknowledge, is due one clock edge after the inputs that cause it are presented. The requests and read data follow the flags and enables with no further delay. The bench therefore drives inputs at the falling edge, lets one rising edge pass, advances a behavioural model by that one step, and compares flags, both requests and read data at the next falling edge. Scenarios cover each clear path alone and together with a set, the wrap and direction-turn cases in both modes, and the gating of each request.

// File: rtl/tifc_pkg.sv
package tifc_pkg;

    localparam int unsigned NSRC    = 2;
    localparam int unsigned SRC_OVF = 0;
    localparam int unsigned SRC_CMP = 1;

    localparam logic SEL_FLAGS = 1'b0;
    localparam logic SEL_ENABL = 1'b1;

endpackage

// File: rtl/tifc_evt.sv
module tifc_evt #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic          dir_up_i,
    input  logic          pwm_i,
    output logic          ovf_evt_o
);

    localparam logic [CW-1:0] TOP = {CW{1'b1}};
    localparam logic [CW-1:0] BOT = '0;

    typedef struct packed {
        logic          vld;
        logic [CW-1:0] cnt;
        logic          dir;
    } hist_t;

    hist_t hist_d, hist_q;
    logic  wrap_w, turn_w;

    always_comb begin
        hist_d     = hist_q;
        hist_d.vld = 1'b1;
        hist_d.cnt = cnt_i;
        hist_d.dir = dir_up_i;

        wrap_w = hist_q.vld && (hist_q.cnt == TOP) && (cnt_i == BOT);
        turn_w = hist_q.vld && !hist_q.dir && dir_up_i && (hist_q.cnt == BOT);

        ovf_evt_o = pwm_i ? turn_w : wrap_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    a_r3_pwm_needs_up: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_i && ovf_evt_o) |-> dir_up_i);

    a_r2_normal_lands_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwm_i && ovf_evt_o) |-> (cnt_i == BOT));

endmodule

// File: rtl/tifc_flag.sv
module tifc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wclr_i,
    input  logic ack_i,
    output logic flag_o
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (wclr_i || ack_i) begin
            flag_d = 1'b0;
        end
        if (set_i) begin
            flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;

    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_o);

    a_r4_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ((wclr_i || ack_i) && !set_i) |=> !flag_o);

    a_r1_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !set_i) |=> !flag_o);

endmodule

// File: rtl/tifc_regs.sv
module tifc_regs
    import tifc_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_i,
    input  logic            wr_i,
    input  logic            rd_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [NSRC-1:0] flags_i,
    output logic [NSRC-1:0] en_o,
    output logic [NSRC-1:0] wclr_o,
    output logic [DW-1:0]   rdata_o
);

    localparam int unsigned PADW = DW - NSRC;

    typedef struct packed {
        logic [NSRC-1:0] en;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        wclr_o = '0;
        if (wr_i) begin
            if (sel_i == SEL_ENABL) begin
                regs_d.en = wdata_i[NSRC-1:0];
            end else begin
                wclr_o = wdata_i[NSRC-1:0];
            end
        end

        rdata_o = '0;
        if (rd_i) begin
            if (sel_i == SEL_ENABL) begin
                rdata_o = {{PADW{1'b0}}, regs_q.en};
            end else begin
                rdata_o = {{PADW{1'b0}}, flags_i};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign en_o = regs_q.en;

    a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |-> (rdata_o[DW-1:NSRC] == '0));

    a_r10_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |-> (rdata_o == '0));

    a_r9_enable_written: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_ENABL) |=> (en_o == $past(wdata_i[NSRC-1:0])));

endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
    import tifc_pkg::*;
#(
    parameter int unsigned CW = 8,
    parameter int unsigned DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [CW-1:0]   cnt_i,
    input  logic            dir_up_i,
    input  logic            pwm_mode_i,
    input  logic            cmp_match_i,
    input  logic            gie_i,
    input  logic            ack_ovf_i,
    input  logic            ack_cmp_i,
    input  logic            bus_sel_i,
    input  logic            bus_wr_i,
    input  logic            bus_rd_i,
    input  logic [DW-1:0]   bus_wdata_i,
    output logic [DW-1:0]   bus_rdata_o,
    output logic [NSRC-1:0] flags_o,
    output logic            irq_ovf_o,
    output logic            irq_cmp_o
);

    logic            ovf_evt;
    logic [NSRC-1:0] set_v, ack_v, wclr_v, en_v, flag_v, req_v;

    tifc_evt #(.CW(CW)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_i     (cnt_i),
        .dir_up_i  (dir_up_i),
        .pwm_i     (pwm_mode_i),
        .ovf_evt_o (ovf_evt)
    );

    tifc_regs #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (bus_sel_i),
        .wr_i    (bus_wr_i),
        .rd_i    (bus_rd_i),
        .wdata_i (bus_wdata_i),
        .flags_i (flag_v),
        .en_o    (en_v),
        .wclr_o  (wclr_v),
        .rdata_o (bus_rdata_o)
    );

    always_comb begin
        set_v          = '0;
        ack_v          = '0;
        set_v[SRC_OVF] = ovf_evt;
        set_v[SRC_CMP] = cmp_match_i;
        ack_v[SRC_OVF] = ack_ovf_i;
        ack_v[SRC_CMP] = ack_cmp_i;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        tifc_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[s]),
            .wclr_i (wclr_v[s]),
            .ack_i  (ack_v[s]),
            .flag_o (flag_v[s])
        );
        assign req_v[s] = gie_i && en_v[s] && flag_v[s];
    end

    assign flags_o   = flag_v;
    assign irq_ovf_o = req_v[SRC_OVF];
    assign irq_cmp_o = req_v[SRC_CMP];

    a_r7_ovf_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ovf_o |-> (gie_i && flags_o[SRC_OVF]));

    a_r7_cmp_gated: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cmp_o |-> (gie_i && flags_o[SRC_CMP]));

    a_r11_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_cmp_i && !cmp_match_i) |=> !irq_cmp_o);

    a_r5_ovf_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_ovf_i && !ovf_evt) |=> !flags_o[SRC_OVF]);

endmodule

// File: tb/tmr_irq_flags_test.sv
module tmr_irq_flags_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cnt = '0;
    logic       dir_up = 1'b1, pwm = 1'b0, cmp = 1'b0, gie = 1'b0;
    logic       ack_ovf = 1'b0, ack_cmp = 1'b0;
    logic       sel = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] flags;
    logic       irq_ovf, irq_cmp;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    // behavioural reference state
    int m_ovf = 0, m_cmp = 0, m_en = 0;
    int m_pcnt = 0, m_pdir = 1, m_vld = 0;

    always #4 clk = ~clk;

    tmr_irq_flags uut (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .dir_up_i(dir_up),
        .pwm_mode_i(pwm), .cmp_match_i(cmp), .gie_i(gie),
        .ack_ovf_i(ack_ovf), .ack_cmp_i(ack_cmp), .bus_sel_i(sel),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .flags_o(flags),
        .irq_ovf_o(irq_ovf), .irq_cmp_o(irq_cmp)
    );

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        int e_rd;
        e_rd = !rd ? 0 : (sel ? m_en : (m_cmp * 2 + m_ovf));
        check({tag, " flags"}, flags, m_cmp * 2 + m_ovf);
        check({tag, " irq_ovf"}, irq_ovf, (gie && m_ovf && (m_en & 1)) ? 1 : 0);
        check({tag, " irq_cmp"}, irq_cmp, (gie && m_cmp && (m_en & 2)) ? 1 : 0);
        check({tag, " rdata"}, rdata, e_rd);
    endtask

    // one clock: model advances on the inputs present before the edge
    task automatic step(string tag);
        int so, sc, co, cc;
        @(posedge clk);
        so = 0;
        if (m_vld) begin
            if (!pwm && m_pcnt == 255 && cnt == 0) so = 1;
            if (pwm && !m_pdir && dir_up && m_pcnt == 0) so = 1;
        end
        sc = cmp;
        co = ack_ovf || (wr && !sel && wdata[0]);
        cc = ack_cmp || (wr && !sel && wdata[1]);
        if (so) m_ovf = 1; else if (co) m_ovf = 0;
        if (sc) m_cmp = 1; else if (cc) m_cmp = 0;
        if (wr && sel) m_en = wdata[1:0];
        m_pcnt = cnt; m_pdir = dir_up; m_vld = 1;
        @(negedge clk);
        compare_all(tag);
        cmp = 0; ack_ovf = 0; ack_cmp = 0; wr = 0;
    endtask

    task automatic bus_write(logic s, logic [7:0] d, string tag);
        sel = s; wr = 1; wdata = d;
        step(tag);
    endtask

    task automatic count(logic [7:0] c, logic d, string tag);
        cnt = c; dir_up = d;
        step(tag);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run ended)");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rd = 1;
        repeat (3) @(negedge clk);
        compare_all("R10 in reset");
        rst_n = 1;
        cnt = 8'd5;
        step("R10 after reset");
        sel = 1;
        step("R10 enables zero");
        rd = 0;
        step("R10 idle bus");
        rd = 1; sel = 0;

        // R1 compare flag
        cmp = 1;
        step("R1 compare set");
        check("R8 compare in bit 1", rdata, 2);
        step("R1 compare held");

        // R9 enables
        bus_write(1, 8'hFF, "R9 enable write");
        check("R9 enable readback", rdata, 3);
        bus_write(1, 8'h01, "R9 enable partial");
        bus_write(1, 8'h03, "R9 enable both");

        // R7 gating
        gie = 1;
        step("R7 irq with gie");
        check("R7 irq_cmp high", irq_cmp, 1);
        bus_write(1, 8'h01, "R7 compare enable off");
        check("R7 irq_cmp masked", irq_cmp, 0);
        bus_write(1, 8'h03, "R7 compare enable on");
        sel = 0;

        // R4 / R8 write-one clear
        bus_write(0, 8'h00, "R4 write zero keeps");
        check("R4 flag kept", flags, 2);
        bus_write(0, 8'hFC, "R8 reserved write ignored");
        check("R8 flag kept", flags, 2);
        bus_write(0, 8'h02, "R4 write one clears");
        check("R11 irq dropped", irq_cmp, 0);

        // R2 normal wrap
        count(8'd254, 1, "R2 approach");
        count(8'd255, 1, "R2 top");
        count(8'd0, 1, "R2 wrap");
        check("R2 overflow set", flags, 1);
        check("R7 irq_ovf high", irq_ovf, 1);
        ack_ovf = 1;
        count(8'd1, 1, "R5 ack ovf");
        check("R11 irq_ovf dropped", irq_ovf, 0);

        // R3 direction turn in normal mode sets nothing
        count(8'd1, 0, "R3 normal down");
        count(8'd0, 0, "R3 normal bottom");
        count(8'd1, 1, "R3 normal turn");
        check("R3 no set in normal", flags, 0);

        // R3 PWM mode
        pwm = 1;
        count(8'd255, 1, "R3 pwm top");
        count(8'd0, 1, "R3 pwm wrap");
        check("R3 wrap ignored in pwm", flags, 0);
        count(8'd1, 0, "R3 pwm down");
        count(8'd0, 0, "R3 pwm bottom");
        count(8'd1, 1, "R3 pwm turn");
        check("R3 pwm overflow set", flags, 1);
        count(8'd2, 1, "R3 pwm up");
        bus_write(0, 8'h01, "R4 clear ovf");
        pwm = 0;

        // R6 set wins
        cmp = 1; sel = 0; wr = 1; wdata = 8'h02;
        step("R6 cmp set vs write");
        check("R6 compare kept", flags, 2);
        cmp = 1; ack_cmp = 1;
        step("R6 cmp set vs ack");
        check("R6 compare kept after ack", flags, 2);
        ack_cmp = 1;
        step("R5 ack cmp");
        check("R5 compare cleared", flags, 0);
        count(8'd255, 1, "R6 top");
        cnt = 8'd0; ack_ovf = 1;
        step("R6 ovf set vs ack");
        check("R6 overflow kept", flags, 1);

        // R7 global bit
        gie = 0;
        step("R7 gie low");
        check("R7 irq_ovf masked", irq_ovf, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule